// File: doc/BRIEF.md
# Line-Addressed Text Streamer

This block keeps a fixed body of text arranged as 64 lines of 64 eight-bit characters. A 6-bit line number picks a line, and a 6-bit cursor picks one character within it. The text is fixed when the design is elaborated. It is built from string constants and simple formulas, so no memory file is needed.

A small controller sits around the text store. A one-cycle start pulse latches the line, the mode and a character count. The controller then sends the line's characters, beginning at index 0, over a byte interface with valid and ready signals. In line-feed mode the stream ends with the line feed character. In count mode it ends after the requested number of characters. A one-cycle done pulse marks the end of each stream.

Top module: `text_line_streamer`

## Requirements
- R1: A line holds 64 characters, addressed by a 6-bit line number and a 6-bit cursor. Cursor 0 returns the leftmost character of the line's string as written.
- R2: The text contents are fixed as follows:
  - Line 0 is "HELLO" followed by 0x0A, and the rest of the line is filled with 0x20.
  - Line 1 is "NO NEWLINE", and the rest of the line is filled with 0x2E.
  - Every line L from 2 to 63 holds, at index i:
    - the letter 0x41 + ((L+i) mod 26) when i < L;
    - 0x0A when i = L;
    - 0x20 when i > L.
- R3: Line-feed mode is selected with `mode_i`=0. The characters of the line are sent in order from index 0. The first 0x0A is sent, and it is the final byte of the stream.
- R4: In line-feed mode, a line with no 0x0A sends all 64 characters (indices 0..63) and then ends with done.
- R5: Count mode is selected with `mode_i`=1. It sends exactly min(`count_i`, 64) characters, starting at index 0. Any count above 64 is treated as 64.
- R6: In count mode, a count of 0 sends no byte. It raises `done_o` in the cycle that follows the start pulse.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` holds its value. The cursor moves forward only when a byte is accepted.
- R8: A start pulse that arrives while `busy_o` is high has no effect. The stream in progress continues unchanged, and no second stream follows it.
- R9: `done_o` is high for one cycle. That cycle is the one right after the cycle in which the last byte is accepted. `out_valid_o` is low whenever `busy_o` is low.
- R10: After reset, `out_valid_o`, `done_o` and `busy_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; only used while idle |
| mode_i | input | 1 | 0 = stop after line feed, 1 = stop after count |
| line_i | input | 6 | Line number to stream |
| count_i | input | 7 | Character count for count mode; values above 64 are clamped |
| out_ready_i | input | 1 | Downstream accepts the byte |
| out_valid_o | output | 1 | A byte is presented |
| out_data_o | output | 8 | Character at the current line and cursor |
| done_o | output | 1 | One-cycle end-of-stream pulse |
| busy_o | output | 1 | Stream in progress |

## Verification
Each accepted byte is checked against a character computed from R2. Because of this, a cursor that skips, repeats or starts off zero shows up at the first mismatching byte. A line latched wrongly shows up at the first byte of the stream. A wrong end decision appears within one cycle of the last expected byte, as an extra byte, a missing byte, or a done pulse at the wrong time. Random stalls on ready expose any cursor that moves without a transfer, because the held byte changes or the following byte comes out wrong.

// File: rtl/tls_pkg.sv
package tls_pkg;
  parameter int LINE_AW  = 6;
  parameter int SEL_W    = 6;
  parameter int DATA_W   = 8;
  localparam int LINE_LEN = 1 << SEL_W;
  localparam int CNT_W    = SEL_W + 1;

  localparam logic [DATA_W-1:0] ASCII_LF = 8'h0A;

  localparam logic MODE_LF  = 1'b0;
  localparam logic MODE_CNT = 1'b1;

  typedef enum logic {ST_IDLE, ST_SEND} stream_state_e;
endpackage

// File: rtl/tls_reset_sync.sv
module tls_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/line_text_rom.sv
module line_text_rom
  import tls_pkg::*;
(
  input  logic [LINE_AW-1:0] line_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [DATA_W-1:0]  char_o
);
  localparam int          GREET_LEN = 6;
  localparam logic [8*GREET_LEN-1:0] GREET_STR = "HELLO\n";
  localparam int          NOTE_LEN  = 10;
  localparam logic [8*NOTE_LEN-1:0]  NOTE_STR  = "NO NEWLINE";

  // Leftmost string character sits in the top byte; cursor 0 maps there.
  function automatic logic [DATA_W-1:0] text_char(input logic [LINE_AW-1:0] l,
                                                  input logic [SEL_W-1:0] s);
    int li;
    int si;
    li = int'(l);
    si = int'(s);
    if (li == 0) begin
      if (si < GREET_LEN) return GREET_STR[8*(GREET_LEN-1-si) +: 8];
      return 8'h20;
    end
    if (li == 1) begin
      if (si < NOTE_LEN) return NOTE_STR[8*(NOTE_LEN-1-si) +: 8];
      return 8'h2E;
    end
    if (si < li)  return DATA_W'(65 + ((li + si) % 26));
    if (si == li) return ASCII_LF;
    return 8'h20;
  endfunction

  always_comb begin
    char_o = text_char(line_i, sel_i);
  end
endmodule

// File: rtl/stream_cursor.sv
module stream_cursor
  import tls_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [SEL_W-1:0] idx_o,
  output logic             at_max_o
);
  logic [SEL_W-1:0] idx_q;
  logic [SEL_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = clr_i | adv_i;
    idx_d  = clr_i ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o    = idx_q;
  assign at_max_o = (idx_q == '1);
endmodule

// File: rtl/stream_ctrl.sv
module stream_ctrl
  import tls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [LINE_AW-1:0] line_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic [DATA_W-1:0]  char_i,
  input  logic [SEL_W-1:0]   idx_i,
  input  logic               at_max_i,
  input  logic               out_ready_i,
  output logic               out_valid_o,
  output logic               done_o,
  output logic               busy_o,
  output logic [LINE_AW-1:0] line_o,
  output logic               cur_clr_o,
  output logic               cur_adv_o
);
  stream_state_e      state_q, state_d;
  logic [LINE_AW-1:0] line_q;
  logic               mode_q;
  logic [CNT_W-1:0]   limit_q;
  logic               done_q, done_d;
  logic               load_en;
  logic               fire;
  logic               last;
  logic [CNT_W-1:0]   clamped;
  logic [CNT_W-1:0]   idx_plus;

  always_comb begin
    clamped  = (count_i > CNT_W'(LINE_LEN)) ? CNT_W'(LINE_LEN) : count_i;
    load_en  = (state_q == ST_IDLE) && start_i;
    fire     = (state_q == ST_SEND) && out_ready_i;
    idx_plus = CNT_W'(idx_i) + CNT_W'(1);
    if (mode_q == MODE_LF) last = (char_i == ASCII_LF) || at_max_i;
    else                   last = (idx_plus == limit_q);

    state_d   = state_q;
    done_d    = 1'b0;
    cur_clr_o = 1'b0;
    cur_adv_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (mode_i == MODE_CNT && clamped == '0) begin
            done_d = 1'b1;
          end else begin
            state_d   = ST_SEND;
            cur_clr_o = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (fire) begin
          if (last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            cur_adv_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      mode_q  <= MODE_LF;
      limit_q <= '0;
    end else if (load_en) begin
      line_q  <= line_i;
      mode_q  <= mode_i;
      limit_q <= clamped;
    end
  end

  assign out_valid_o = (state_q == ST_SEND);
  assign busy_o      = (state_q == ST_SEND);
  assign done_o      = done_q;
  assign line_o      = line_q;

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(char_i)));

  assert_cursor_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_adv_o |=> (idx_i == SEL_W'($past(idx_i) + 1'b1)));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && mode_q == MODE_CNT) |-> (CNT_W'(idx_i) < limit_q));

  assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && mode_i == MODE_CNT && count_i == '0) |=> (done_o && !out_valid_o));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(line_q) && $stable(limit_q) && $stable(mode_q)));
endmodule

// File: rtl/text_line_streamer.sv
module text_line_streamer
  import tls_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               mode_i,
  input  logic [LINE_AW-1:0] line_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               out_ready_i,
  output logic               out_valid_o,
  output logic [DATA_W-1:0]  out_data_o,
  output logic               done_o,
  output logic               busy_o
);
  logic               rst_n_s;
  logic [LINE_AW-1:0] line_q;
  logic [SEL_W-1:0]   idx;
  logic               at_max;
  logic               cur_clr;
  logic               cur_adv;
  logic [DATA_W-1:0]  rom_char;

  tls_reset_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  line_text_rom i_rom (
    .line_i (line_q),
    .sel_i  (idx),
    .char_o (rom_char)
  );

  stream_cursor i_cursor (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr_i    (cur_clr),
    .adv_i    (cur_adv),
    .idx_o    (idx),
    .at_max_o (at_max)
  );

  stream_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .line_i      (line_i),
    .count_i     (count_i),
    .char_i      (rom_char),
    .idx_i       (idx),
    .at_max_i    (at_max),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .done_o      (done_o),
    .busy_o      (busy_o),
    .line_o      (line_q),
    .cur_clr_o   (cur_clr),
    .cur_adv_o   (cur_adv)
  );

  assign out_data_o = rom_char;
endmodule

// File: tb/test_text_line_streamer.sv
module test_text_line_streamer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic       mode_i;
  logic [5:0] line_i;
  logic [6:0] count_i;
  logic       out_ready_i;
  logic       out_valid_o;
  logic [7:0] out_data_o;
  logic       done_o;
  logic       busy_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_hs = -1;
  int done_seen = 0;
  logic [7:0] exp_q[$];
  string cur_req = "R3";
  bit stall_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 0;
  logic [7:0] prev_data = '0;

  always #5 clk = ~clk;

  text_line_streamer i_text_line_streamer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .line_i(line_i), .count_i(count_i), .out_ready_i(out_ready_i),
    .out_valid_o(out_valid_o), .out_data_o(out_data_o),
    .done_o(done_o), .busy_o(busy_o)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_char(int l, int i);
    string s;
    if (l == 0) begin
      s = "HELLO\n";
      return (i < s.len()) ? s[i] : 8'h20;
    end
    if (l == 1) begin
      s = "NO NEWLINE";
      return (i < s.len()) ? s[i] : 8'h2E;
    end
    if (i < l)  return 8'(65 + (l + i) % 26);
    if (i == l) return 8'h0A;
    return 8'h20;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (stall_en) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready_i = lfsr[0] | lfsr[5];
    end else begin
      out_ready_i = 1'b1;
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && out_valid_o)
        check(out_data_o == prev_data, "R7", "byte changed while stalled", out_data_o, prev_data);
      if (prev_stall)
        check(out_valid_o, "R7", "valid dropped while stalled", out_valid_o, 1);
      prev_stall = out_valid_o && !out_ready_i;
      prev_data  = out_data_o;
      if (!busy_o)
        check(!out_valid_o, "R9", "valid while idle", out_valid_o, 0);
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected extra byte", out_data_o, -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(out_data_o == e, cur_req, "streamed byte", out_data_o, e);
        end
        last_hs = cyc;
      end
      if (done_o) begin
        if (last_hs >= 0)
          check(cyc == last_hs + 1, "R9", "done cycle", cyc, last_hs + 1);
        last_hs = -1;
        done_seen++;
      end
    end
  end

  task automatic pulse_start(bit m, int l, int c);
    @(posedge clk); #1;
    start_i = 1'b1; mode_i = m; line_i = 6'(l); count_i = 7'(c);
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic load_expect(bit m, int l, int c);
    int n = 0;
    int lim;
    lim = (c > 64) ? 64 : c;
    for (int i = 0; i < 64; i++) begin
      logic [7:0] ch;
      ch = exp_char(l, i);
      if (m && n >= lim) break;
      exp_q.push_back(ch);
      n++;
      if (!m && ch == 8'h0A) break;
    end
  endtask

  task automatic wait_done(int ds0, string req);
    int n = 0;
    while (done_seen == ds0 && n < 1000) begin
      @(posedge clk);
      n++;
    end
    check(done_seen == ds0 + 1, req, "done pulse count", done_seen - ds0, 1);
    check(exp_q.size() == 0, req, "missing bytes", exp_q.size(), 0);
    @(negedge clk);
    check(!busy_o, req, "busy after done", busy_o, 0);
  endtask

  task automatic run_stream(bit m, int l, int c, bit stall, string req);
    int ds0;
    stall_en = stall;
    cur_req = req;
    load_expect(m, l, c);
    ds0 = done_seen;
    pulse_start(m, l, c);
    wait_done(ds0, req);
    stall_en = 0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ds0;
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; line_i = '0; count_i = '0;
    out_ready_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!out_valid_o && !done_o && !busy_o, "R10", "reset state",
          {out_valid_o, done_o, busy_o}, 0);

    run_stream(1'b0, 0, 0, 1'b0, "R1 R2 R3 line0");
    run_stream(1'b0, 5, 0, 1'b1, "R2 R3 R7 line5");
    run_stream(1'b0, 63, 0, 1'b0, "R2 R3 R4 line63");
    run_stream(1'b0, 1, 0, 1'b1, "R2 R4 noLF");
    run_stream(1'b1, 1, 4, 1'b0, "R1 R5 count4");
    run_stream(1'b1, 30, 64, 1'b0, "R2 R5 count64");
    run_stream(1'b1, 2, 100, 1'b1, "R5 clamp100");
    run_stream(1'b1, 0, 1, 1'b0, "R5 count1");

    // R6: zero count
    ds0 = done_seen;
    cur_req = "R6";
    pulse_start(1'b1, 7, 0);
    @(negedge clk);
    check(done_o == 1'b1, "R6", "done after zero count", done_o, 1);
    check(!out_valid_o, "R6", "valid on zero count", out_valid_o, 0);
    repeat (3) @(posedge clk);
    check(done_seen == ds0 + 1, "R6", "done pulses", done_seen - ds0, 1);

    // R8: start while busy is ignored
    stall_en = 1;
    cur_req = "R8";
    load_expect(1'b0, 10, 0);
    ds0 = done_seen;
    pulse_start(1'b0, 10, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(busy_o, "R8", "busy before second start", busy_o, 1);
    pulse_start(1'b1, 20, 3);
    wait_done(ds0, "R8");
    stall_en = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!busy_o && done_seen == ds0 + 1, "R8", "no second stream",
          done_seen - ds0, 1);

    run_stream(1'b0, 40, 0, 1'b1, "R2 R3 line40");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule